// File: doc/BRIEF.md
# Remote Persistence Flush Ordering Engine

This block serves the responder end of one remote-memory connection. It takes a single ordered stream of four operation kinds: posted writes, flushes, 8-byte atomic writes and range verifies. Posted writes enter a small write buffer. The buffer drains in arrival order to a memory-side write port that uses a valid/ready handshake. Posted writes never produce a response.

A flush covers every write that arrived on the connection before it. It is answered once all of those writes have been accepted by the memory port. When the flush asks for persistence, the answer also waits for a persist request/done handshake. Writes that arrive after a flush keep flowing into the buffer and down to memory while the flush is outstanding. A new atomic write, verify or flush is held off until the pending non-posted operation has finished.

A verify folds a range of memory words into a check value and compares it with the value carried in the request. By default the fold is XOR; a parameter selects an additive fold instead. On a mismatch, the verify either returns an error response or breaks the connection. A broken connection silently swallows all later traffic until reset.

Top module: `rpf_engine`

## Requirements
- R1: After reset `rsp_valid`, `mem_wr_valid`, `persist_req` and `conn_broken` are 0, and a posted write is offered `op_ready` = 1.
- R2: The write buffer holds `DEPTH` writes. A posted write (`op_kind` 0) sees `op_ready` = 0 only while the buffer is full. Posted writes never produce a response.
- R3: Buffered writes reach the memory port in arrival order, at word address `op_addr >> 3`. While `mem_wr_ready` is 0, the port holds its address and data stable.
- R4: A flush (`op_kind` 1) responds with kind 1 and status 0 only after every write received before it has been accepted by the memory port. With `op_flags[0]` = 1 (persist), `persist_req` rises only after that point, stays high until `persist_done`, and the response follows `persist_done`.
- R5: Posted writes presented while a flush is outstanding are accepted, and they drain to memory before that flush responds.
- R6: While a flush, atomic write or verify is outstanding, any new non-posted operation sees `op_ready` = 0. Responses leave in request order.
- R7: An atomic write (`op_kind` 2) at an address with `op_addr[2:0]` = 0 writes its 64-bit data to word `op_addr >> 3`. Once that write is accepted by the memory port, it responds with kind 2 and status 0.
- R8: An atomic write with `op_addr[2:0]` != 0 responds with kind 2 and status 1, and performs no memory write.
- R9: A verify (`op_kind` 3) folds `op_len` words starting at word `op_addr >> 3` and compares the result with `op_data`. With `op_len` = 0 the fold value is 0. A match responds with kind 3 and status 0.
- R10: A verify mismatch with `op_flags[1]` = 0 responds with kind 3 and status 1, and the connection stays usable.
- R11: A verify mismatch with `op_flags[1]` = 1 sends no response and sets `conn_broken`. `conn_broken` stays set until reset. From then on every operation is accepted and discarded, with no memory write and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation accepted this cycle when op_valid is also high |
| op_kind | input | 2 | 0 write, 1 flush, 2 atomic write, 3 verify |
| op_flags | input | 2 | Bit 0: flush persistence. Bit 1: verify mismatch breaks the connection |
| op_addr | input | ADDR_W | Byte address |
| op_len | input | LEN_W | Verify length in 64-bit words |
| op_data | input | DATA_W | Write data, or the expected fold value for a verify |
| mem_wr_valid | output | 1 | Memory write present |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W-3 | Memory word address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_rd_addr | output | ADDR_W-3 | Verify read word address |
| mem_rd_data | input | DATA_W | Verify read data, combinational from mem_rd_addr |
| persist_req | output | 1 | Request to push accepted writes into the persistence domain |
| persist_done | input | 1 | Persistence step finished |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_kind | output | 2 | Kind of the operation being answered |
| rsp_status | output | 1 | 0 success, 1 error |
| conn_broken | output | 1 | Sticky connection-broken flag |

## Verification
The bench builds the engine with `DEPTH` = 4, `ADDR_W` = 9 and `LEN_W` = 4. This gives a 64-word memory that the bench models in full. It can therefore fill the buffer to its limit and hold the memory port stalled across a whole flush. With those values it runs verifies over every length from 0 to 7 at three base offsets, including windows that straddle other writes. It computes each expected XOR arithmetically from the generated word pattern. The small buffer lets the bench overlap posted writes, a persist flush and a stalled atomic write within a few cycles, and check the response order and the drain order directly at the ports.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_FLUSH  = 2'd1,
      OP_ATOMIC = 2'd2,
      OP_VERIFY = 2'd3
   } op_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_VIS,
      ST_PERSIST,
      ST_VERIFY
   } seq_state_e;

   localparam int FLG_PERSIST = 0;
   localparam int FLG_DROP    = 1;

   localparam logic RSP_OK  = 1'b0;
   localparam logic RSP_ERR = 1'b1;
endpackage

// File: rtl/rpf_wbuf.sv
module rpf_wbuf #(
   parameter int DEPTH   = 4,
   parameter int DATA_W  = 64,
   parameter int WADDR_W = 13,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int TAG_W  = PTR_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_i,
   input  logic [WADDR_W-1:0] push_addr_i,
   input  logic [DATA_W-1:0]  push_data_i,
   output logic               full_o,
   output logic               out_valid_o,
   input  logic               out_ready_i,
   output logic [WADDR_W-1:0] out_addr_o,
   output logic [DATA_W-1:0]  out_data_o,
   output logic [TAG_W-1:0]   enq_tag_o,
   output logic [TAG_W-1:0]   drn_tag_o
);
   logic [WADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0]  data_q [DEPTH];
   logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
   logic [PTR_W:0]     fill_q;
   logic [TAG_W-1:0]   enq_q, drn_q;
   logic               pop;

   assign full_o      = (fill_q == (PTR_W+1)'(DEPTH));
   assign out_valid_o = (fill_q != '0);
   assign out_addr_o  = addr_q[rd_ptr_q];
   assign out_data_o  = data_q[rd_ptr_q];
   assign pop         = out_valid_o && out_ready_i;
   assign enq_tag_o   = enq_q;
   assign drn_tag_o   = drn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         fill_q   <= '0;
         enq_q    <= '0;
         drn_q    <= '0;
      end else begin
         if (push_i) begin
            wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            enq_q    <= enq_q + TAG_W'(1);
         end
         if (pop) begin
            rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            drn_q    <= drn_q + TAG_W'(1);
         end
         if (push_i && !pop)      fill_q <= fill_q + (PTR_W+1)'(1);
         else if (!push_i && pop) fill_q <= fill_q - (PTR_W+1)'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push_i) begin
         addr_q[wr_ptr_q] <= push_addr_i;
         data_q[wr_ptr_q] <= push_data_i;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o); // R2

   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_addr_o) && $stable(out_data_o))); // R3
endmodule

// File: rtl/rpf_vchk.sv
module rpf_vchk #(
   parameter int DATA_W   = 64,
   parameter int WADDR_W  = 13,
   parameter int LEN_W    = 4,
   parameter bit USE_SUM  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [WADDR_W-1:0] base_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic [DATA_W-1:0]  expect_i,
   output logic [WADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0]  rd_data_i,
   output logic               done_o,
   output logic               match_o
);
   logic               busy_q;
   logic [LEN_W-1:0]   idx_q, len_q;
   logic [WADDR_W-1:0] base_q;
   logic [DATA_W-1:0]  acc_q, exp_q, acc_nxt;

   generate
      if (USE_SUM) begin : g_sum
         assign acc_nxt = acc_q + rd_data_i;
      end else begin : g_xor
         assign acc_nxt = acc_q ^ rd_data_i;
      end
   endgenerate

   assign rd_addr_o = base_q + WADDR_W'(idx_q);
   assign done_o    = busy_q && (idx_q == len_q);
   assign match_o   = (acc_q == exp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         len_q  <= '0;
         base_q <= '0;
         acc_q  <= '0;
         exp_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         len_q  <= len_i;
         base_q <= base_i;
         acc_q  <= '0;
         exp_q  <= expect_i;
      end else if (busy_q) begin
         if (idx_q == len_q) begin
            busy_q <= 1'b0;
         end else begin
            acc_q <= acc_nxt;
            idx_q <= idx_q + LEN_W'(1);
         end
      end
   end

   AST_FOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q <= len_q)); // R9
endmodule

// File: rtl/rpf_seq.sv
module rpf_seq
   import rpf_pkg::*;
#(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid_i,
   input  logic [1:0]       op_kind_i,
   input  logic [2:0]       op_addr_lo_i,
   input  logic [1:0]       op_flags_i,
   output logic             op_ready_o,
   output logic             wb_push_o,
   input  logic             wb_full_i,
   input  logic [TAG_W-1:0] enq_tag_i,
   input  logic [TAG_W-1:0] drn_tag_i,
   output logic             vchk_start_o,
   input  logic             vchk_done_i,
   input  logic             vchk_match_i,
   output logic             persist_req_o,
   input  logic             persist_done_i,
   output logic             rsp_valid_o,
   output logic [1:0]       rsp_kind_o,
   output logic             rsp_status_o,
   output logic             broken_o
);
   op_kind_e         kind;
   seq_state_e       state_q;
   logic [TAG_W-1:0] tgt_q;
   logic             want_p_q, drop_q, broken_q;
   logic             rsp_valid_q, rsp_status_q;
   logic [1:0]       rsp_kind_q, cur_kind_q;
   logic             aligned, accept, vis_done;

   assign kind     = op_kind_e'(op_kind_i);
   assign aligned  = (op_addr_lo_i == 3'd0);
   assign vis_done = (drn_tag_i == tgt_q);

   always_comb begin
      if (broken_q)                         op_ready_o = 1'b1;
      else if (kind == OP_WRITE)            op_ready_o = !wb_full_i;
      else if (state_q != ST_IDLE)          op_ready_o = 1'b0;
      else if (kind == OP_ATOMIC && aligned) op_ready_o = !wb_full_i;
      else                                  op_ready_o = 1'b1;
   end

   assign accept        = op_valid_i && op_ready_o && !broken_q;
   assign wb_push_o     = accept && ((kind == OP_WRITE) || (kind == OP_ATOMIC && aligned));
   assign vchk_start_o  = accept && (kind == OP_VERIFY);
   assign persist_req_o = (state_q == ST_PERSIST);
   assign rsp_valid_o   = rsp_valid_q;
   assign rsp_kind_o    = rsp_kind_q;
   assign rsp_status_o  = rsp_status_q;
   assign broken_o      = broken_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         tgt_q        <= '0;
         want_p_q     <= 1'b0;
         drop_q       <= 1'b0;
         broken_q     <= 1'b0;
         cur_kind_q   <= 2'd0;
         rsp_valid_q  <= 1'b0;
         rsp_kind_q   <= 2'd0;
         rsp_status_q <= RSP_OK;
      end else begin
         rsp_valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  cur_kind_q <= op_kind_i;
                  unique case (kind)
                     OP_FLUSH: begin
                        tgt_q    <= enq_tag_i;
                        want_p_q <= op_flags_i[FLG_PERSIST];
                        state_q  <= ST_VIS;
                     end
                     OP_ATOMIC: begin
                        if (aligned) begin
                           tgt_q    <= enq_tag_i + TAG_W'(1);
                           want_p_q <= 1'b0;
                           state_q  <= ST_VIS;
                        end else begin
                           rsp_valid_q  <= 1'b1;
                           rsp_kind_q   <= op_kind_i;
                           rsp_status_q <= RSP_ERR;
                        end
                     end
                     OP_VERIFY: begin
                        drop_q  <= op_flags_i[FLG_DROP];
                        state_q <= ST_VERIFY;
                     end
                     default: ;
                  endcase
               end
            end
            ST_VIS: begin
               if (vis_done) begin
                  if (want_p_q) begin
                     state_q <= ST_PERSIST;
                  end else begin
                     rsp_valid_q  <= 1'b1;
                     rsp_kind_q   <= cur_kind_q;
                     rsp_status_q <= RSP_OK;
                     state_q      <= ST_IDLE;
                  end
               end
            end
            ST_PERSIST: begin
               if (persist_done_i) begin
                  rsp_valid_q  <= 1'b1;
                  rsp_kind_q   <= cur_kind_q;
                  rsp_status_q <= RSP_OK;
                  state_q      <= ST_IDLE;
               end
            end
            ST_VERIFY: begin
               if (vchk_done_i) begin
                  state_q <= ST_IDLE;
                  if (vchk_match_i) begin
                     rsp_valid_q  <= 1'b1;
                     rsp_kind_q   <= cur_kind_q;
                     rsp_status_q <= RSP_OK;
                  end else if (drop_q) begin
                     broken_q <= 1'b1;
                  end else begin
                     rsp_valid_q  <= 1'b1;
                     rsp_kind_q   <= cur_kind_q;
                     rsp_status_q <= RSP_ERR;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_PERSIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (persist_req_o && !persist_done_i) |=> persist_req_o); // R4

   AST_BROKEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      broken_q |=> broken_q); // R11

   AST_SILENT_BROKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (broken_q && $past(broken_q)) |-> !rsp_valid_q); // R11
endmodule

// File: rtl/rpf_engine.sv
module rpf_engine #(
   parameter int DEPTH     = 4,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 64,
   parameter int LEN_W     = 4,
   parameter bit SUM_CHECK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic [1:0]        op_kind,
   input  logic [1:0]        op_flags,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [LEN_W-1:0]  op_len,
   input  logic [DATA_W-1:0] op_data,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-4:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic [ADDR_W-4:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              persist_req,
   input  logic              persist_done,
   output logic              rsp_valid,
   output logic [1:0]        rsp_kind,
   output logic              rsp_status,
   output logic              conn_broken
);
   localparam int WA_W  = ADDR_W - 3;
   localparam int TAG_W = $clog2(DEPTH) + 2;

   initial begin
      assert (DATA_W == 64) else $error("data width must be 64");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0) else $error("depth must be a power of two");
      assert (LEN_W < WA_W) else $error("length field too wide");
   end

   logic             wb_push, wb_full;
   logic [TAG_W-1:0] enq_tag, drn_tag;
   logic             vchk_start, vchk_done, vchk_match;

   rpf_seq #(.TAG_W(TAG_W)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .op_valid_i     (op_valid),
      .op_kind_i      (op_kind),
      .op_addr_lo_i   (op_addr[2:0]),
      .op_flags_i     (op_flags),
      .op_ready_o     (op_ready),
      .wb_push_o      (wb_push),
      .wb_full_i      (wb_full),
      .enq_tag_i      (enq_tag),
      .drn_tag_i      (drn_tag),
      .vchk_start_o   (vchk_start),
      .vchk_done_i    (vchk_done),
      .vchk_match_i   (vchk_match),
      .persist_req_o  (persist_req),
      .persist_done_i (persist_done),
      .rsp_valid_o    (rsp_valid),
      .rsp_kind_o     (rsp_kind),
      .rsp_status_o   (rsp_status),
      .broken_o       (conn_broken)
   );

   rpf_wbuf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .WADDR_W(WA_W)) u_wbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (wb_push),
      .push_addr_i (op_addr[ADDR_W-1:3]),
      .push_data_i (op_data),
      .full_o      (wb_full),
      .out_valid_o (mem_wr_valid),
      .out_ready_i (mem_wr_ready),
      .out_addr_o  (mem_wr_addr),
      .out_data_o  (mem_wr_data),
      .enq_tag_o   (enq_tag),
      .drn_tag_o   (drn_tag)
   );

   rpf_vchk #(.DATA_W(DATA_W), .WADDR_W(WA_W), .LEN_W(LEN_W), .USE_SUM(SUM_CHECK)) u_vchk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (vchk_start),
      .base_i    (op_addr[ADDR_W-1:3]),
      .len_i     (op_len),
      .expect_i  (op_data),
      .rd_addr_o (mem_rd_addr),
      .rd_data_i (mem_rd_data),
      .done_o    (vchk_done),
      .match_o   (vchk_match)
   );

   AST_RSP_NEEDS_IDLE_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(persist_req) |-> rsp_valid); // R4
endmodule

// File: tb/rpf_engine_tb.sv
`timescale 1ns/1ps
module rpf_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [1:0]  op_kind = 2'd0;
   logic [1:0]  op_flags = 2'd0;
   logic [8:0]  op_addr = '0;
   logic [3:0]  op_len = '0;
   logic [63:0] op_data = '0;
   logic        mem_wr_valid, mem_wr_ready = 1'b1;
   logic [5:0]  mem_wr_addr, mem_rd_addr;
   logic [63:0] mem_wr_data, mem_rd_data;
   logic        persist_req, persist_done = 1'b0;
   logic        rsp_valid, rsp_status, conn_broken;
   logic [1:0]  rsp_kind;

   logic [63:0] mem [64] = '{default: '0};
   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [1:0] rk [256];
   logic       rs [256];
   int rsp_n = 0, rsp_rd = 0;

   always #10 clk = ~clk;

   rpf_engine #(.DEPTH(4), .ADDR_W(9), .DATA_W(64), .LEN_W(4), .SUM_CHECK(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_kind(op_kind), .op_flags(op_flags), .op_addr(op_addr), .op_len(op_len),
      .op_data(op_data), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .persist_req(persist_req), .persist_done(persist_done),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_status(rsp_status),
      .conn_broken(conn_broken)
   );

   assign mem_rd_data = mem[mem_rd_addr];
   always @(posedge clk) if (mem_wr_valid && mem_wr_ready) mem[mem_wr_addr] <= mem_wr_data;

   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_n < 256) begin
         rk[rsp_n] = rsp_kind;
         rs[rsp_n] = rsp_status;
         rsp_n++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic logic [63:0] pat(input int i);
      return (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1)) ^ (64'(i) << 32);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] k, input logic [8:0] a, input logic [63:0] d,
                       input logic [3:0] l, input logic [1:0] f);
      @(negedge clk);
      op_valid = 1'b1; op_kind = k; op_addr = a; op_data = d; op_len = l; op_flags = f;
      #2;
      while (!op_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic probe(input logic [1:0] k, input logic [8:0] a, output logic r);
      @(negedge clk);
      op_valid = 1'b1; op_kind = k; op_addr = a; op_flags = 2'd0;
      #2;
      r = op_ready;
      #1;
      op_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string req, input logic [1:0] k, input logic s);
      int w = 0;
      while (rsp_n <= rsp_rd && w < 300) begin
         @(negedge clk);
         w++;
      end
      if (rsp_n <= rsp_rd) begin
         chk(1'b0, req, "missing response", 64'd0, {61'd0, k, s});
      end else begin
         chk(rk[rsp_rd] == k && rs[rsp_rd] == s, req, "response kind/status",
             {61'd0, rk[rsp_rd], rs[rsp_rd]}, {61'd0, k, s});
         rsp_rd++;
      end
   endtask

   initial begin
      logic r;
      logic [63:0] held, e;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R1 reset state
      chk(op_ready == 1'b1 && rsp_valid == 1'b0 && mem_wr_valid == 1'b0 &&
          persist_req == 1'b0 && conn_broken == 1'b0, "R1", "reset outputs",
          {59'd0, op_ready, rsp_valid, mem_wr_valid, persist_req, conn_broken}, 64'h10);

      // R2 / R3: fill buffer with memory stalled
      mem_wr_ready = 1'b0;
      for (int i = 0; i < 4; i++) send(2'd0, 9'(i * 8), pat(i + 40), 4'd0, 2'd0);
      probe(2'd0, 9'd32, r);
      chk(r == 1'b0, "R2", "write ready with full buffer", 64'(r), 64'd0);
      chk(rsp_n == 0, "R2", "posted writes produce no response", 64'(rsp_n), 64'd0);
      @(negedge clk); #2;
      held = mem_wr_data;
      chk(mem_wr_valid && mem_wr_addr == 6'd0, "R3", "oldest write at port",
          {57'd0, mem_wr_valid, mem_wr_addr}, 64'h40);
      repeat (3) @(negedge clk);
      #2;
      chk(mem_wr_data == held && mem_wr_addr == 6'd0, "R3", "port held while stalled",
          mem_wr_data, held);

      // R4 visibility flush waits for drain; R6 stall of non-posted
      send(2'd1, 9'd0, 64'd0, 4'd0, 2'd0);
      repeat (8) @(negedge clk);
      chk(rsp_n == 0, "R4", "flush answered before drain", 64'(rsp_n), 64'd0);
      probe(2'd2, 9'd80, r);
      chk(r == 1'b0, "R6", "atomic ready while flush pending", 64'(r), 64'd0);
      mem_wr_ready = 1'b1;
      expect_rsp("R4", 2'd1, 1'b0);
      for (int i = 0; i < 4; i++)
         chk(mem[i] == pat(i + 40), "R3", $sformatf("word %0d after flush", i), mem[i], pat(i + 40));

      // R5 / R4 persist flush with later writes flowing
      mem_wr_ready = 1'b0;
      send(2'd0, 9'd40, pat(5), 4'd0, 2'd0);
      send(2'd0, 9'd48, pat(6), 4'd0, 2'd0);
      send(2'd1, 9'd0, 64'd0, 4'd0, 2'd1);
      probe(2'd0, 9'd56, r);
      chk(r == 1'b1, "R5", "write ready while flush pending", 64'(r), 64'd1);
      send(2'd0, 9'd56, pat(7), 4'd0, 2'd0);
      chk(persist_req == 1'b0, "R4", "persist before visibility", 64'(persist_req), 64'd0);
      mem_wr_ready = 1'b1;
      repeat (8) @(negedge clk);
      #2;
      chk(persist_req == 1'b1, "R4", "persist request after drain", 64'(persist_req), 64'd1);
      chk(mem[7] == pat(7), "R5", "later write drained during flush", mem[7], pat(7));
      chk(rsp_n == rsp_rd, "R4", "no response before persist done", 64'(rsp_n - rsp_rd), 64'd0);
      @(negedge clk); persist_done = 1'b1;
      @(negedge clk); persist_done = 1'b0;
      expect_rsp("R4", 2'd1, 1'b0);

      // R7 aligned atomic
      send(2'd2, 9'd80, 64'hA5A5_0000_1234_5678, 4'd0, 2'd0);
      expect_rsp("R7", 2'd2, 1'b0);
      chk(mem[10] == 64'hA5A5_0000_1234_5678, "R7", "atomic data", mem[10], 64'hA5A5_0000_1234_5678);

      // R8 misaligned atomic
      send(2'd2, 9'd83, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 2'd0);
      expect_rsp("R8", 2'd2, 1'b1);
      repeat (4) @(negedge clk);
      chk(mem[10] == 64'hA5A5_0000_1234_5678, "R8", "no memory write", mem[10], 64'hA5A5_0000_1234_5678);

      // R6 response order: flush then stalled atomic
      mem_wr_ready = 1'b0;
      send(2'd0, 9'd88, pat(11), 4'd0, 2'd0);
      send(2'd1, 9'd0, 64'd0, 4'd0, 2'd0);
      fork
         begin repeat (6) @(negedge clk); mem_wr_ready = 1'b1; end
      join_none
      send(2'd2, 9'd96, 64'h0BAD_F00D, 4'd0, 2'd0);
      expect_rsp("R6", 2'd1, 1'b0);
      expect_rsp("R6", 2'd2, 1'b0);

      // R9 sweep: fill words 0..15, flush, verify windows
      for (int i = 0; i < 16; i++) send(2'd0, 9'(i * 8), pat(i), 4'd0, 2'd0);
      send(2'd1, 9'd0, 64'd0, 4'd0, 2'd0);
      expect_rsp("R9", 2'd1, 1'b0);
      for (int b = 0; b < 3; b++) begin
         for (int l = 0; l < 8; l++) begin
            int base = (b == 0) ? 0 : (b == 1) ? 3 : 8;
            e = '0;
            for (int j = 0; j < l; j++) e = e ^ pat(base + j);
            send(2'd3, 9'(base * 8), e, 4'(l), 2'd0);
            expect_rsp($sformatf("R9 base %0d len %0d", base, l), 2'd3, 1'b0);
         end
      end

      // R10 mismatch, error mode
      send(2'd3, 9'd0, pat(0) ^ pat(1) ^ 64'd1, 4'd2, 2'd0);
      expect_rsp("R10", 2'd3, 1'b1);
      chk(conn_broken == 1'b0, "R10", "connection kept", 64'(conn_broken), 64'd0);
      send(2'd3, 9'd0, pat(0), 4'd1, 2'd0);
      expect_rsp("R10", 2'd3, 1'b0);

      // R11 mismatch, drop mode
      send(2'd3, 9'd0, 64'd7, 4'd1, 2'd2);
      repeat (30) @(negedge clk);
      chk(rsp_n == rsp_rd, "R11", "no response on drop", 64'(rsp_n - rsp_rd), 64'd0);
      chk(conn_broken == 1'b1, "R11", "broken flag", 64'(conn_broken), 64'd1);
      send(2'd0, 9'd160, 64'hDEAD_BEEF, 4'd0, 2'd0);
      repeat (10) @(negedge clk);
      chk(mem[20] == 64'd0, "R11", "write discarded", mem[20], 64'd0);
      send(2'd1, 9'd0, 64'd0, 4'd0, 2'd0);
      repeat (20) @(negedge clk);
      chk(rsp_n == rsp_rd, "R11", "flush discarded", 64'(rsp_n - rsp_rd), 64'd0);
      chk(conn_broken == 1'b1, "R11", "flag sticky", 64'(conn_broken), 64'd1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule